// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a small 32-bit processor from the moment a fault, trap or interrupt is recognised up to the fetch of the first handler instruction. The core presents one request with a type code, the pending interrupt level, its status register (SR), the faulting and next program counters, the stack pointer and the vector base register. The sequencer then runs a fixed series of steps. It switches the SR to supervisor state. For interrupts it reads the vector number through an acknowledge cycle. It pushes a two-word frame onto the supervisor stack, reads the handler address from the vector table and raises a one-cycle start strobe that carries the new PC.

All memory traffic goes over one simple request/acknowledge bus that is shared by the stack writes, the acknowledge read and the table read. A bus error at any point of the sequence is taken as a double fault: the block stops in a halt state that only reset clears.

The state machine has these states: IDLE, SR_ADJ, IACK, PUSH_FMT, PUSH_PC, VEC_RD, START and HALT.
- IDLE goes to SR_ADJ when a request arrives.
- SR_ADJ goes to IACK for interrupts and to PUSH_FMT for every other type.
- IACK goes to PUSH_FMT when the bus acknowledges.
- PUSH_FMT goes to PUSH_PC when the bus acknowledges.
- PUSH_PC goes to VEC_RD when the bus acknowledges.
- VEC_RD goes to START when the bus acknowledges.
- START returns to IDLE after one cycle.
- A bus error in IACK, PUSH_FMT, PUSH_PC or VEC_RD goes to HALT, and HALT has no exit except reset.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, busy, bus_req, handler_start and halt are 0, and sr_out, sp_out and handler_pc are 0.
- R2: A request (req_valid high) is accepted only in IDLE. A request made while busy is ignored, and the running sequence's bus traffic and results are unchanged.
- R3: The new SR is the old SR with bit 13 (supervisor) set and bit 15 (trace) cleared. For interrupts, bit 12 (master) is also cleared and bits 10:8 (priority mask) take irq_level. For other types, bits 12 and 10:8 keep their old values.
- R4: Non-interrupt vector numbers follow the type code: 0 access error gives 2, 1 address error gives 3, 2 illegal opcode gives 4, 3 divide by zero gives 5, 4 privilege gives 8, 5 trace gives 9, 7 format error gives 14, and 8..15 (trap 0..7) give 32..39. Type 6 is an interrupt.
- R5: An interrupt performs exactly one read with bus_iack=1 at address 0xFFFF_FFE0 + 4*level, before any stack write. The vector number is bus_rdata[7:0].
- R6: The SP is first aligned down to a multiple of 4 (A). The first write goes to A-8 and the second to A-4. sp_out becomes A-8.
- R7: The word written at A-8 is: bits 31:28 = 4, bits 27:26 = 0, bits 25:18 = vector number, bits 17:16 = 0, bits 15:0 = the SR value from before entry.
- R8: The word written at A-4 is pc_fault for types 0-4 and 7, and pc_next for types 5, 6 and 8-15.
- R9: The vector is read (bus_we=0, bus_iack=0) from {vbr_in[31:20], 20'h0} + 4*vector.
- R10: handler_start is high for exactly one cycle after the vector read completes, with handler_pc equal to the data read. busy is 0 in the following cycle.
- R11: bus_req, bus_we, bus_addr and bus_wdata stay unchanged while a bus access waits for bus_ack or bus_err.
- R12: bus_err during any access sets halt, which stays at 1 until reset. After it there is no further bus request and no handler_start, and new requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request |
| req_type | input | 4 | Exception type code (R4) |
| irq_level | input | 3 | Level of the interrupt being taken |
| sr_in | input | 16 | Current status register |
| pc_fault | input | 32 | Address of the faulting instruction |
| pc_next | input | 32 | Address of the next instruction |
| sp_in | input | 32 | Current supervisor stack pointer |
| vbr_in | input | 32 | Vector base register |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write |
| bus_iack | output | 1 | Access is an interrupt-acknowledge cycle |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access complete |
| bus_err | input | 1 | Access failed |
| busy | output | 1 | Sequence in progress or halted |
| sr_out | output | 16 | Updated status register |
| sp_out | output | 32 | Stack pointer after the frame push |
| handler_pc | output | 32 | First handler instruction address |
| handler_start | output | 1 | One-cycle strobe to start the handler fetch |
| halt | output | 1 | Double-fault halt |

## Verification
The bench aims at the following corner cases, and each one exposes a specific class of design error:
- A level-5 interrupt over an SR that has trace and master set. A design that treats interrupts like faults leaves the mask and master bit wrong, or skips the acknowledge read.
- An access error with a stack pointer ending in binary 11. A design that does not align the stack pointer writes its frame to unaligned addresses that are off by three.
- Traps and trace with wait states. These catch the wrong stacked PC and a bus request that drifts while it waits for bus_ack.
- A request made mid-sequence. This catches a design that restarts itself on that request.
- A bus error on the PC push. A design that fails to stop keeps issuing bus requests or starts the handler after the error.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
    localparam int XLEN   = 32;
    localparam int SR_W   = 16;
    localparam int VEC_W  = 8;
    localparam int LVL_W  = 3;
    localparam int TYPE_W = 4;

    // status register bit positions
    localparam int SR_TRACE = 15;
    localparam int SR_SUPV  = 13;
    localparam int SR_MSTR  = 12;
    localparam int SR_IPL   = 8;

    // exception type codes
    localparam logic [TYPE_W-1:0] EXC_ACCESS  = 4'd0;
    localparam logic [TYPE_W-1:0] EXC_ADDRESS = 4'd1;
    localparam logic [TYPE_W-1:0] EXC_ILLEGAL = 4'd2;
    localparam logic [TYPE_W-1:0] EXC_DIVZERO = 4'd3;
    localparam logic [TYPE_W-1:0] EXC_PRIV    = 4'd4;
    localparam logic [TYPE_W-1:0] EXC_TRACE   = 4'd5;
    localparam logic [TYPE_W-1:0] EXC_IRQ     = 4'd6;
    localparam logic [TYPE_W-1:0] EXC_FORMAT  = 4'd7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SR_ADJ,
        ST_IACK,
        ST_PUSH_FMT,
        ST_PUSH_PC,
        ST_VEC_RD,
        ST_START,
        ST_HALT
    } seq_state_t;
endpackage

// File: rtl/exc_vec_map.sv
module exc_vec_map
    import exc_seq_pkg::*;
(
    input  logic [TYPE_W-1:0] exc_type,
    output logic [VEC_W-1:0]  vec_num,
    output logic              use_next_pc,
    output logic              is_irq
);
    localparam logic [VEC_W-1:0] TRAP_BASE = 8'd32;

    always_comb begin
        is_irq      = 1'b0;
        use_next_pc = 1'b0;
        vec_num     = '0;
        if (exc_type[TYPE_W-1]) begin
            vec_num     = TRAP_BASE + VEC_W'(exc_type[TYPE_W-2:0]);
            use_next_pc = 1'b1;
        end else begin
            unique case (exc_type)
                EXC_ACCESS:  vec_num = 8'd2;
                EXC_ADDRESS: vec_num = 8'd3;
                EXC_ILLEGAL: vec_num = 8'd4;
                EXC_DIVZERO: vec_num = 8'd5;
                EXC_PRIV:    vec_num = 8'd8;
                EXC_TRACE: begin
                    vec_num     = 8'd9;
                    use_next_pc = 1'b1;
                end
                EXC_IRQ: begin
                    is_irq      = 1'b1;
                    use_next_pc = 1'b1;
                end
                EXC_FORMAT:  vec_num = 8'd14;
                default:     vec_num = 8'd4;
            endcase
        end
    end
endmodule

// File: rtl/exc_sr_update.sv
module exc_sr_update
    import exc_seq_pkg::*;
(
    input  logic [SR_W-1:0]  sr_old,
    input  logic             is_irq,
    input  logic [LVL_W-1:0] level,
    output logic [SR_W-1:0]  sr_new
);
    always_comb begin
        sr_new           = sr_old;
        sr_new[SR_TRACE] = 1'b0;
        sr_new[SR_SUPV]  = 1'b1;
        if (is_irq) begin
            sr_new[SR_MSTR]                 = 1'b0;
            sr_new[SR_IPL +: LVL_W]         = level;
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter logic [XLEN-1:0] IACK_BASE = 32'hFFFF_FFE0,
    parameter logic [3:0]      FRAME_FMT = 4'h4,
    parameter int              VBR_KEEP  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [TYPE_W-1:0] req_type,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic [SR_W-1:0]   sr_in,
    input  logic [XLEN-1:0]   pc_fault,
    input  logic [XLEN-1:0]   pc_next,
    input  logic [XLEN-1:0]   sp_in,
    input  logic [XLEN-1:0]   vbr_in,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_iack,
    output logic [XLEN-1:0]   bus_addr,
    output logic [XLEN-1:0]   bus_wdata,
    input  logic [XLEN-1:0]   bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    output logic              busy,
    output logic [SR_W-1:0]   sr_out,
    output logic [XLEN-1:0]   sp_out,
    output logic [XLEN-1:0]   handler_pc,
    output logic              handler_start,
    output logic              halt
);
    localparam int VBR_LOW = XLEN - VBR_KEEP;
    localparam int PAD_W   = VBR_LOW - VEC_W - 2;

    seq_state_t state_q, state_d;

    logic [VEC_W-1:0]  map_vec;
    logic              map_next, map_irq;
    logic [SR_W-1:0]   sr_adj;

    logic              irq_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [SR_W-1:0]   sr_save_q;
    logic [XLEN-1:0]   pc_q;
    logic [XLEN-1:0]   sp_al_q;
    logic [VBR_KEEP-1:0] vbr_q;
    logic [VEC_W-1:0]  vec_q;
    logic [SR_W-1:0]   sr_q;
    logic [XLEN-1:0]   sp_q;
    logic [XLEN-1:0]   hpc_q;

    logic              accept;
    logic              done_ok;

    exc_vec_map u_map (
        .exc_type    (req_type),
        .vec_num     (map_vec),
        .use_next_pc (map_next),
        .is_irq      (map_irq)
    );

    exc_sr_update u_sr (
        .sr_old (sr_save_q),
        .is_irq (irq_q),
        .level  (lvl_q),
        .sr_new (sr_adj)
    );

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign done_ok = bus_req && bus_ack && !bus_err;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_d = ST_SR_ADJ;
            ST_SR_ADJ:   state_d = irq_q ? ST_IACK : ST_PUSH_FMT;
            ST_IACK:     if (bus_err) state_d = ST_HALT;
                         else if (bus_ack) state_d = ST_PUSH_FMT;
            ST_PUSH_FMT: if (bus_err) state_d = ST_HALT;
                         else if (bus_ack) state_d = ST_PUSH_PC;
            ST_PUSH_PC:  if (bus_err) state_d = ST_HALT;
                         else if (bus_ack) state_d = ST_VEC_RD;
            ST_VEC_RD:   if (bus_err) state_d = ST_HALT;
                         else if (bus_ack) state_d = ST_START;
            ST_START:    state_d = ST_IDLE;
            ST_HALT:     state_d = ST_HALT;
            default:     state_d = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured context and results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q     <= 1'b0;
            lvl_q     <= '0;
            sr_save_q <= '0;
            pc_q      <= '0;
            sp_al_q   <= '0;
            vbr_q     <= '0;
            vec_q     <= '0;
            sr_q      <= '0;
            sp_q      <= '0;
            hpc_q     <= '0;
        end else begin
            if (accept) begin
                irq_q     <= map_irq;
                lvl_q     <= irq_level;
                sr_save_q <= sr_in;
                pc_q      <= map_next ? pc_next : pc_fault;
                sp_al_q   <= {sp_in[XLEN-1:2], 2'b00};
                vbr_q     <= vbr_in[XLEN-1 -: VBR_KEEP];
                vec_q     <= map_vec;
            end
            if (state_q == ST_SR_ADJ) sr_q <= sr_adj;
            if (state_q == ST_IACK && done_ok) vec_q <= bus_rdata[VEC_W-1:0];
            if (state_q == ST_PUSH_PC && done_ok) sp_q <= sp_al_q - XLEN'(8);
            if (state_q == ST_VEC_RD && done_ok) hpc_q <= bus_rdata;
        end
    end

    // outputs
    always_comb begin
        bus_req       = 1'b0;
        bus_we        = 1'b0;
        bus_iack      = 1'b0;
        bus_addr      = '0;
        bus_wdata     = '0;
        handler_start = 1'b0;
        halt          = 1'b0;
        busy          = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IACK: begin
                bus_req  = 1'b1;
                bus_iack = 1'b1;
                bus_addr = IACK_BASE | {{(XLEN-LVL_W-2){1'b0}}, lvl_q, 2'b00};
            end
            ST_PUSH_FMT: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = sp_al_q - XLEN'(8);
                bus_wdata = {FRAME_FMT, 2'b00, vec_q, 2'b00, sr_save_q};
            end
            ST_PUSH_PC: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = sp_al_q - XLEN'(4);
                bus_wdata = pc_q;
            end
            ST_VEC_RD: begin
                bus_req  = 1'b1;
                bus_addr = {vbr_q, {PAD_W{1'b0}}, vec_q, 2'b00};
            end
            ST_START: handler_start = 1'b1;
            ST_HALT:  halt = 1'b1;
            default: ;
        endcase
    end

    assign sr_out     = sr_q;
    assign sp_out     = sp_q;
    assign handler_pc = hpc_q;

    // R10
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        handler_start |=> !handler_start && !busy);

    // R12
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt && !bus_req && !handler_start);

    // R11
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !bus_err) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R6
    write_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> (bus_addr[1:0] == 2'b00));

    // R5
    iack_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_iack |-> (bus_req && !bus_we));

    // R3
    start_super_chk: assert property (@(posedge clk) disable iff (!rst_n)
        handler_start |-> (sr_out[SR_SUPV] && !sr_out[SR_TRACE]));
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_type = '0;
    logic [2:0]  irq_level = '0;
    logic [15:0] sr_in = '0;
    logic [31:0] pc_fault = '0, pc_next = '0, sp_in = '0, vbr_in = '0;
    logic        bus_req, bus_we, bus_iack;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0, bus_err = 1'b0;
    logic        busy, handler_start, halt;
    logic [15:0] sr_out;
    logic [31:0] sp_out, handler_pc;

    exc_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .irq_level(irq_level), .sr_in(sr_in), .pc_fault(pc_fault), .pc_next(pc_next),
        .sp_in(sp_in), .vbr_in(vbr_in), .bus_req(bus_req), .bus_we(bus_we),
        .bus_iack(bus_iack), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err), .busy(busy),
        .sr_out(sr_out), .sp_out(sp_out), .handler_pc(handler_pc),
        .handler_start(handler_start), .halt(halt)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic        we;
        logic        iack;
        logic [31:0] addr;
        logic [31:0] wdata;
        int          rq;
    } txn_t;

    txn_t exp_q[$];
    int   checks = 0;
    int   fails = 0;
    int   wait_cfg = 0;
    int   wait_cnt = 0;
    int   txn_idx = 0;
    int   err_at = -1;
    logic [7:0] iack_vec = 8'h40;
    bit   finished = 1'b0;

    function automatic string rq_name(input int n);
        case (n)
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            9: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // R4: vector numbers by type code
    function automatic logic [7:0] ref_vec(input logic [3:0] t);
        if (t >= 4'd8) return 8'd32 + 8'(t - 4'd8);
        case (t)
            4'd0: return 8'd2;
            4'd1: return 8'd3;
            4'd2: return 8'd4;
            4'd3: return 8'd5;
            4'd4: return 8'd8;
            4'd5: return 8'd9;
            4'd7: return 8'd14;
            default: return 8'd0;
        endcase
    endfunction

    // R3: expected status register
    function automatic logic [15:0] ref_sr(input logic [15:0] s, input bit irq,
                                           input logic [2:0] lvl);
        logic [15:0] r;
        r = s;
        r[15] = 1'b0;
        r[13] = 1'b1;
        if (irq) begin
            r[12] = 1'b0;
            r[10:8] = lvl;
        end
        return r;
    endfunction

    // bus responder and per-clock comparison against the expected traffic
    always @(negedge clk) begin
        bus_ack = 1'b0;
        bus_err = 1'b0;
        if (rst_n && bus_req) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12", "unexpected bus request", bus_addr, 32'h0);
            end else begin
                chk(bus_addr == exp_q[0].addr && bus_we == exp_q[0].we &&
                    bus_iack == exp_q[0].iack &&
                    (!exp_q[0].we || bus_wdata == exp_q[0].wdata),
                    rq_name(exp_q[0].rq), "bus access addr", bus_addr, exp_q[0].addr);
                if (exp_q[0].we)
                    chk(bus_wdata == exp_q[0].wdata, rq_name(exp_q[0].rq),
                        "bus write data", bus_wdata, exp_q[0].wdata);
            end
            if (wait_cnt < wait_cfg) begin
                wait_cnt++;
            end else begin
                wait_cnt = 0;
                if (txn_idx == err_at) begin
                    bus_err = 1'b1;
                end else begin
                    bus_ack = 1'b1;
                    bus_rdata = bus_iack ? {24'h0, iack_vec} : bus_addr + 32'h4000_0000;
                end
                txn_idx++;
                if (exp_q.size() != 0) void'(exp_q.pop_front());
            end
        end else begin
            wait_cnt = 0;
        end
    end

    task automatic check_reset_state();
        @(negedge clk);
        chk(busy == 1'b0 && bus_req == 1'b0, "R1", "busy/bus_req after reset",
            {30'h0, busy, bus_req}, 32'h0);
        chk(handler_start == 1'b0 && halt == 1'b0, "R1", "start/halt after reset",
            {30'h0, handler_start, halt}, 32'h0);
        chk(sr_out == 16'h0 && sp_out == 32'h0 && handler_pc == 32'h0, "R1",
            "result registers after reset", handler_pc | sp_out | {16'h0, sr_out}, 32'h0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_exc(input logic [3:0] t, input logic [2:0] lvl,
                           input logic [15:0] sr, input logic [31:0] pcf,
                           input logic [31:0] pcn, input logic [31:0] sp,
                           input logic [31:0] vbr, input int waits,
                           input int errat, input bit poke);
        bit          irq;
        bit          nxt;
        logic [7:0]  v;
        logic [31:0] al, vaddr;
        bit          started;
        bit          halted;
        txn_t        tx;
        irq = (t == 4'd6);
        nxt = irq || t == 4'd5 || t >= 4'd8;
        v   = irq ? iack_vec : ref_vec(t);
        al  = sp & ~32'h3;
        vaddr = (vbr & 32'hFFF0_0000) + {22'h0, v, 2'b00};
        if (irq) begin
            tx = '{we: 1'b0, iack: 1'b1, addr: 32'hFFFF_FFE0 + {27'h0, lvl, 2'b00},
                   wdata: 32'h0, rq: 5};
            exp_q.push_back(tx);
        end
        tx = '{we: 1'b1, iack: 1'b0, addr: al - 32'd8,
               wdata: {4'h4, 2'b00, v, 2'b00, sr}, rq: 7};
        exp_q.push_back(tx);
        tx = '{we: 1'b1, iack: 1'b0, addr: al - 32'd4, wdata: nxt ? pcn : pcf, rq: 8};
        exp_q.push_back(tx);
        tx = '{we: 1'b0, iack: 1'b0, addr: vaddr, wdata: 32'h0, rq: 9};
        exp_q.push_back(tx);
        wait_cfg = waits;
        err_at   = errat;
        txn_idx  = 0;

        @(negedge clk);
        req_valid = 1'b1; req_type = t; irq_level = lvl; sr_in = sr;
        pc_fault = pcf; pc_next = pcn; sp_in = sp; vbr_in = vbr;
        @(negedge clk);
        req_valid = 1'b0;
        started = 1'b0;
        halted  = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (handler_start) begin started = 1'b1; break; end
            if (halt) begin halted = 1'b1; break; end
            @(negedge clk);
            if (poke && i == 2) begin
                // R2: request while busy, with different context
                req_valid = 1'b1; req_type = 4'd2; sp_in = 32'h0000_1000;
                pc_fault = 32'hDEAD_0000; sr_in = 16'h0000;
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;

        if (errat < 0) begin
            chk(started, "R10", "handler_start seen", {31'h0, started}, 32'h1);
            chk(handler_pc == vaddr + 32'h4000_0000, "R10", "handler_pc",
                handler_pc, vaddr + 32'h4000_0000);
            chk(sr_out == ref_sr(sr, irq, lvl), "R3", "sr_out",
                {16'h0, sr_out}, {16'h0, ref_sr(sr, irq, lvl)});
            chk(sp_out == al - 32'd8, "R6", "sp_out", sp_out, al - 32'd8);
            chk(exp_q.size() == 0, "R2", "all expected accesses done",
                exp_q.size(), 32'h0);
            @(negedge clk);
            chk(handler_start == 1'b0 && busy == 1'b0, "R10", "strobe one cycle, idle after",
                {30'h0, handler_start, busy}, 32'h0);
        end else begin
            chk(halted && !started, "R12", "halt after bus error",
                {30'h0, halted, started}, 32'h2);
            exp_q.delete();
            for (int k = 0; k < 5; k++) begin
                req_valid = (k == 1);
                @(negedge clk);
                chk(halt == 1'b1 && bus_req == 1'b0 && handler_start == 1'b0, "R12",
                    "halt held, bus quiet", {29'h0, halt, bus_req, handler_start}, 32'h4);
            end
            req_valid = 1'b0;
        end
    endtask

    initial begin
        do_reset();
        check_reset_state();

        // R3 R5 R6 R7 R8 R9: level-5 interrupt over SR with trace and master set
        iack_vec = 8'h47;
        run_exc(4'd6, 3'd5, 16'h9213, 32'h1000_0100, 32'h1000_0104,
                32'h0000_8000, 32'h1234_5678, 0, -1, 1'b0);

        // R4 R6 R8: access error with misaligned SP
        run_exc(4'd0, 3'd0, 16'h8704, 32'h2000_0040, 32'h2000_0042,
                32'h0000_9003, 32'h0010_0000, 0, -1, 1'b0);

        // R4 R8 R11: trap 3 with wait states
        run_exc(4'd11, 3'd0, 16'h0300, 32'h3000_0010, 32'h3000_0012,
                32'h0001_0002, 32'hABC0_0000, 2, -1, 1'b0);

        // R2 R4: trace exception, request poked while busy
        run_exc(4'd5, 3'd0, 16'h8000, 32'h4000_0020, 32'h4000_0024,
                32'h0002_0000, 32'h0000_0000, 1, -1, 1'b1);

        // R3 R5: level-7 interrupt, vector 0xFF, wait states
        iack_vec = 8'hFF;
        run_exc(4'd6, 3'd7, 16'h2000, 32'h5000_0000, 32'h5000_0002,
                32'h0003_0001, 32'hFFF0_0000, 1, -1, 1'b0);

        // R4: format error
        run_exc(4'd7, 3'd0, 16'h0010, 32'h6000_0000, 32'h6000_0004,
                32'h0004_0000, 32'h0020_0000, 0, -1, 1'b0);

        // R12: bus error on the PC push
        run_exc(4'd4, 3'd0, 16'h0000, 32'h7000_0000, 32'h7000_0002,
                32'h0005_0000, 32'h0030_0000, 0, 1, 1'b0);

        // R1: reset clears halt
        do_reset();
        check_reset_state();

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule